// File: doc/BRIEF.md
# Deferred-fill accumulate cache

This block is a direct-mapped cache with one line per index. It serves a stream of accumulate packets. Each packet carries a word address and an operand. The operand is added into the word that the address names. When the address is already resident, the sum is formed in the line in a single cycle and the line is marked as modified.

When the address is not resident, the block does not fetch first and then modify. If the line that must make room holds modified data, its contents are first sent to memory as a writeback. In the cycle that writeback is acknowledged, the incoming operand replaces the line outright, under the new tag. The line is flagged as waiting. Only then is a fill request issued for the new address. The returned memory image is added on top of the operand already in the line.

Because the writeback and the operand store form one step, and the fill request only follows them, the fetched image can never be summed into the departing line's data. While a line waits for its fill, packets to that index are held off. Hits to other indices continue to be served.

Top module: `acc_fill_cache`

## Requirements
- R1: After reset every line reads as invalid, `pkt_ready` is high and neither memory request is active.
- R2: A packet whose address is resident is accepted in one cycle. From the next cycle the line holds the old value plus the operand, and the line is marked dirty. No memory request is made for it.
- R3: On a miss whose victim line is valid and dirty, the block first raises a writeback request. The request carries the victim's full address (victim tag over the index) and its data. It holds them unchanged until `wb_ack`.
- R4: On a miss whose victim line is invalid, no writeback is made.
- R5: The packet operand is stored in the cycle the writeback completes, or at acceptance when there is no writeback. It is stored under the new tag, and the line is then valid, dirty and pending. This happens before any fill request is raised.
- R6: The fill request carries the packet address and holds it until `fill_rsp_valid`. On the response, the returned word is added to the line and the pending flag clears.
- R7: A writeback request and a fill request are never active in the same cycle. A fill request for a miss is only raised after that miss's writeback has completed.
- R8: While a line is pending, `pkt_ready` is low for any packet whose index bits match it, whatever its tag. Packets that hit other lines are still accepted.
- R9: While a fill is outstanding, a packet that misses in another line is held (`pkt_ready` low).
- R10: All sums wrap modulo 2^DATA_W, both for hit additions and for fill additions.
- R11: At every clock, each word reads as the total of its initial memory image plus every accepted operand for that address. The word is taken from the resident line, from line plus memory while pending, and otherwise from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet accepted this cycle when valid |
| pkt_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| pkt_data | input | DATA_W | Operand to accumulate |
| wb_req_valid | output | 1 | Writeback request active |
| wb_req_addr | output | ADDR_W | Writeback word address |
| wb_req_data | output | DATA_W | Writeback data |
| wb_ack | input | 1 | Writeback completed |
| fill_req_valid | output | 1 | Fill request active |
| fill_req_addr | output | ADDR_W | Fill word address |
| fill_rsp_valid | input | 1 | Fill data returned |
| fill_rsp_data | input | DATA_W | Memory image of the fill address |
| rd_idx | input | IDX_W | Line selected for inspection |
| rd_valid | output | 1 | Selected line valid |
| rd_dirty | output | 1 | Selected line modified |
| rd_pend | output | 1 | Selected line waiting for its fill |
| rd_tag | output | ADDR_W-IDX_W | Selected line tag |
| rd_data | output | DATA_W | Selected line data |

## Verification
The main function is driven in four ways:
- Hits on a resident line, which separate the one-cycle add path from the miss path.
- Misses into empty lines, which show that no writeback occurs.
- Misses onto dirty victims with slow writeback and fill responses, which expose whether the operand lands before the fill and whether the victim data leaves intact.
- Traffic offered during a pending fill, at the same index, at another resident line and as another miss, which separates the hold rules from the hit path.

A long random phase over a narrow address range forces frequent evictions with varied memory latencies. A behavioural model of per-address totals then tells a correctly ordered fill-add from one that mixes data between addresses.

// File: rtl/acc_fill_pkg.sv
package acc_fill_pkg;

  // operation on the primary line write port
  typedef enum logic [1:0] {
    OPA_NONE  = 2'd0,
    OPA_HIT   = 2'd1,
    OPA_ALLOC = 2'd2
  } opa_e;

  // miss sequencer state
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } seq_st_e;

endpackage

// File: rtl/acc_line_store.sv
module acc_line_store
  import acc_fill_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // primary port: hit add or allocate
  input  opa_e              opa,
  input  logic [IDX_W-1:0]  opa_idx,
  input  logic [TAG_W-1:0]  opa_tag,
  input  logic [DATA_W-1:0] opa_data,
  // fill port: add returned image, clear pending
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_data,
  // lookup for the incoming packet
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  // inspection port
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic              rd_pend,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NLINE = 1 << IDX_W;

  logic [NLINE-1:0]  vld_q;
  logic [NLINE-1:0]  drt_q;
  logic [NLINE-1:0]  pnd_q;
  logic [TAG_W-1:0]  tag_q [NLINE];
  logic [DATA_W-1:0] dat_q [NLINE];

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic              sel_a;
    logic              sel_f;
    logic              en;
    logic              vld_d, drt_d, pnd_d;
    logic              vld_r, drt_r, pnd_r;
    logic [TAG_W-1:0]  tag_d, tag_r;
    logic [DATA_W-1:0] dat_d, dat_r;

    assign sel_a = (opa != OPA_NONE) && (opa_idx == IDX_W'(g));
    assign sel_f = fill_en && (fill_idx == IDX_W'(g));
    assign en    = sel_a || sel_f;

    always_comb begin
      vld_d = vld_r;
      drt_d = drt_r;
      pnd_d = pnd_r;
      tag_d = tag_r;
      dat_d = dat_r;
      if (sel_a && (opa == OPA_HIT)) begin
        dat_d = dat_r + opa_data;
        drt_d = 1'b1;
      end
      if (sel_a && (opa == OPA_ALLOC)) begin
        vld_d = 1'b1;
        drt_d = 1'b1;
        pnd_d = 1'b1;
        tag_d = opa_tag;
        dat_d = opa_data;
      end
      if (sel_f) begin
        dat_d = dat_r + fill_data;
        pnd_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        drt_r <= 1'b0;
        pnd_r <= 1'b0;
      end else if (en) begin
        vld_r <= vld_d;
        drt_r <= drt_d;
        pnd_r <= pnd_d;
      end
    end

    always_ff @(posedge clk) begin
      if (en) begin
        tag_r <= tag_d;
        dat_r <= dat_d;
      end
    end

    assign vld_q[g] = vld_r;
    assign drt_q[g] = drt_r;
    assign pnd_q[g] = pnd_r;
    assign tag_q[g] = tag_r;
    assign dat_q[g] = dat_r;
  end

  assign lk_valid = vld_q[lk_idx];
  assign lk_dirty = drt_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = dat_q[lk_idx];

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];
  assign rd_pend  = pnd_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];

  // R6: a fill-add only ever lands on a line that is waiting for it
  a_r6_fill_hits_pending: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (pnd_q[fill_idx] && vld_q[fill_idx]));

  // R8: the two write ports never target the same line in one cycle
  a_r8_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (opa != OPA_NONE)) |-> (opa_idx != fill_idx));

  // R5: an allocation leaves the line valid, dirty and pending
  a_r5_alloc_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (opa == OPA_ALLOC) |=> (pnd_q[$past(opa_idx)] && vld_q[$past(opa_idx)]
                            && drt_q[$past(opa_idx)]));

endmodule

// File: rtl/acc_miss_ctrl.sv
module acc_miss_ctrl
  import acc_fill_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [ADDR_W-1:0] pkt_addr,
  input  logic [DATA_W-1:0] pkt_data,
  // lookup result for pkt index
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  // line write ports
  output opa_e              opa,
  output logic [IDX_W-1:0]  opa_idx,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opa_data,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [DATA_W-1:0] fill_data,
  // memory side
  output logic              wb_req_valid,
  output logic [ADDR_W-1:0] wb_req_addr,
  output logic [DATA_W-1:0] wb_req_data,
  input  logic              wb_ack,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data
);

  seq_st_e           st_q, st_d;
  logic              cap;
  logic              hit;
  logic [IDX_W-1:0]  p_idx;
  logic [TAG_W-1:0]  p_tag;

  logic [IDX_W-1:0]  pidx_q;
  logic [TAG_W-1:0]  ptag_q;
  logic [DATA_W-1:0] pdat_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [DATA_W-1:0] vdat_q;

  assign p_idx = pkt_addr[IDX_W-1:0];
  assign p_tag = pkt_addr[ADDR_W-1:IDX_W];
  assign hit   = lk_valid && (lk_tag == p_tag);

  always_comb begin
    st_d           = st_q;
    cap            = 1'b0;
    pkt_ready      = 1'b0;
    opa            = OPA_NONE;
    opa_idx        = p_idx;
    opa_tag        = p_tag;
    opa_data       = pkt_data;
    fill_en        = 1'b0;
    wb_req_valid   = 1'b0;
    fill_req_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        pkt_ready = 1'b1;
        if (pkt_valid) begin
          if (hit) begin
            opa = OPA_HIT;
          end else if (lk_valid && lk_dirty) begin
            cap  = 1'b1;
            st_d = ST_WB;
          end else begin
            opa  = OPA_ALLOC;
            cap  = 1'b1;
            st_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        wb_req_valid = 1'b1;
        if (wb_ack) begin
          // store the operand in the same step as the eviction
          opa      = OPA_ALLOC;
          opa_idx  = pidx_q;
          opa_tag  = ptag_q;
          opa_data = pdat_q;
          st_d     = ST_FILL;
        end
      end
      ST_FILL: begin
        fill_req_valid = 1'b1;
        pkt_ready      = hit && (p_idx != pidx_q);
        if (pkt_valid && hit && (p_idx != pidx_q)) begin
          opa = OPA_HIT;
        end
        if (fill_rsp_valid) begin
          fill_en = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      pidx_q  <= p_idx;
      ptag_q  <= p_tag;
      pdat_q  <= pkt_data;
      vaddr_q <= {lk_tag, p_idx};
      vdat_q  <= lk_data;
    end
  end

  assign wb_req_addr   = vaddr_q;
  assign wb_req_data   = vdat_q;
  assign fill_req_addr = {ptag_q, pidx_q};
  assign fill_idx      = pidx_q;
  assign fill_data     = fill_rsp_data;

  // R7: eviction and fill are never requested together
  a_r7_wb_fill_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req_valid && fill_req_valid));

  // R3: writeback request stays put until acknowledged
  a_r3_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && !wb_ack) |=>
      (wb_req_valid && $stable(wb_req_addr) && $stable(wb_req_data)));

  // R6: fill request stays put until answered
  a_r6_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=>
      (fill_req_valid && $stable(fill_req_addr)));

  // R7: the fill for an evicting miss follows its completed writeback
  a_r7_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && wb_ack) |=> (fill_req_valid && !wb_req_valid));

endmodule

// File: rtl/acc_fill_cache.sv
module acc_fill_cache
  import acc_fill_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [ADDR_W-1:0] pkt_addr,
  input  logic [DATA_W-1:0] pkt_data,
  output logic              wb_req_valid,
  output logic [ADDR_W-1:0] wb_req_addr,
  output logic [DATA_W-1:0] wb_req_data,
  input  logic              wb_ack,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic              rd_pend,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0_q, rst_s1_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_int_n = rst_s1_q;

  opa_e              opa;
  logic [IDX_W-1:0]  opa_idx;
  logic [TAG_W-1:0]  opa_tag;
  logic [DATA_W-1:0] opa_data;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [DATA_W-1:0] fill_data;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;

  acc_miss_ctrl #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .pkt_valid      (pkt_valid),
    .pkt_ready      (pkt_ready),
    .pkt_addr       (pkt_addr),
    .pkt_data       (pkt_data),
    .lk_valid       (lk_valid),
    .lk_dirty       (lk_dirty),
    .lk_tag         (lk_tag),
    .lk_data        (lk_data),
    .opa            (opa),
    .opa_idx        (opa_idx),
    .opa_tag        (opa_tag),
    .opa_data       (opa_data),
    .fill_en        (fill_en),
    .fill_idx       (fill_idx),
    .fill_data      (fill_data),
    .wb_req_valid   (wb_req_valid),
    .wb_req_addr    (wb_req_addr),
    .wb_req_data    (wb_req_data),
    .wb_ack         (wb_ack),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_data  (fill_rsp_data)
  );

  acc_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .opa       (opa),
    .opa_idx   (opa_idx),
    .opa_tag   (opa_tag),
    .opa_data  (opa_data),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_data (fill_data),
    .lk_idx    (pkt_addr[IDX_W-1:0]),
    .lk_valid  (lk_valid),
    .lk_dirty  (lk_dirty),
    .lk_tag    (lk_tag),
    .lk_data   (lk_data),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_pend   (rd_pend),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data)
  );

  // R8: a packet aimed at the waiting line's index is never taken
  a_r8_pending_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fill_req_valid && pkt_valid &&
     (pkt_addr[IDX_W-1:0] == fill_req_addr[IDX_W-1:0])) |-> !pkt_ready);

  // R1: no memory traffic straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!wb_req_valid && !fill_req_valid));

endmodule

// File: tb/acc_fill_cache_tb.sv
module acc_fill_cache_tb;

  localparam int CLK_P  = 20;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int NL     = 1 << IDX_W;
  localparam int NA     = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              pkt_valid;
  logic              pkt_ready;
  logic [ADDR_W-1:0] pkt_addr;
  logic [DATA_W-1:0] pkt_data;
  logic              wb_req_valid;
  logic [ADDR_W-1:0] wb_req_addr;
  logic [DATA_W-1:0] wb_req_data;
  logic              wb_ack;
  logic              fill_req_valid;
  logic [ADDR_W-1:0] fill_req_addr;
  logic              fill_rsp_valid;
  logic [DATA_W-1:0] fill_rsp_data;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid, rd_dirty, rd_pend;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;

  acc_fill_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .wb_req_valid(wb_req_valid), .wb_req_addr(wb_req_addr),
    .wb_req_data(wb_req_data), .wb_ack(wb_ack),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_pend(rd_pend), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  // reference and memory model
  logic [DATA_W-1:0] mem      [NA];
  logic [DATA_W-1:0] ref_sum  [NA];
  int                checks = 0;
  int                errors = 0;
  int                wb_lat = 0, fill_lat = 0;
  int                wb_count = 0, fill_count = 0;
  logic [ADDR_W-1:0] last_wb_a;
  logic [DATA_W-1:0] last_wb_d;
  logic              infl_v = 1'b0;
  logic [ADDR_W-1:0] infl_a;
  logic              chk_on = 1'b0;
  logic              done = 1'b0;

  // per-cycle snapshot of all lines
  logic              sv [NL];
  logic              sd [NL];
  logic              sp [NL];
  logic [TAG_W-1:0]  stg [NL];
  logic [DATA_W-1:0] sdat [NL];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_res(input logic [ADDR_W-1:0] a);
    int i;
    i = int'(a[IDX_W-1:0]);
    return sv[i] && (stg[i] == a[ADDR_W-1:IDX_W]);
  endfunction

  // R11: whole-memory comparison against the reference on every clock
  task automatic check_state();
    logic              bad;
    logic [ADDR_W-1:0] ba;
    logic [DATA_W-1:0] bact, bexp;
    bad = 1'b0;
    ba = '0; bact = '0; bexp = '0;
    for (int i = 0; i < NL; i++) begin
      if (sv[i]) begin
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] v;
        a = {stg[i], IDX_W'(i)};
        if (infl_v && infl_a == a) infl_v = 1'b0;
        v = sp[i] ? DATA_W'(sdat[i] + mem[a]) : sdat[i];
        if (v != ref_sum[a] && !bad) begin
          bad = 1'b1; ba = a; bact = v; bexp = ref_sum[a];
        end
      end
    end
    for (int a = 0; a < NA; a++) begin
      logic [ADDR_W-1:0] aa;
      aa = ADDR_W'(a);
      if (!is_res(aa) && !(infl_v && infl_a == aa)) begin
        if (mem[aa] != ref_sum[aa] && !bad) begin
          bad = 1'b1; ba = aa; bact = mem[aa]; bexp = ref_sum[aa];
        end
      end
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R11 addr=%0h act=%0h exp=%0h", ba, bact, bexp);
    end
  endtask

  initial begin
    rd_idx = '0;
    forever begin
      @(posedge clk);
      #2;
      for (int i = 0; i < NL; i++) begin
        rd_idx = IDX_W'(i);
        #1;
        sv[i] = rd_valid; sd[i] = rd_dirty; sp[i] = rd_pend;
        stg[i] = rd_tag; sdat[i] = rd_data;
      end
      if (chk_on && !done) check_state();
    end
  end

  // memory model: writes on ack, returns image on fill
  initial begin
    int wc, fc;
    wc = 0; fc = 0;
    wb_ack = 1'b0; fill_rsp_valid = 1'b0; fill_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (wb_ack) begin
        wb_ack = 1'b0; wc = 0;
      end else if (wb_req_valid && rst_n) begin
        if (wc >= wb_lat) begin
          wb_ack = 1'b1;
          mem[wb_req_addr] = wb_req_data;
          wb_count++; last_wb_a = wb_req_addr; last_wb_d = wb_req_data;
        end else wc++;
      end
      if (fill_rsp_valid) begin
        fill_rsp_valid = 1'b0; fc = 0;
      end else if (fill_req_valid && rst_n) begin
        if (fc >= fill_lat) begin
          fill_rsp_valid = 1'b1;
          fill_rsp_data  = mem[fill_req_addr];
          fill_count++;
        end else fc++;
      end
    end
  end

  task automatic note_accept(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    if (!is_res(a)) begin
      infl_v = 1'b1; infl_a = a;
    end
    ref_sum[a] = ref_sum[a] + d;
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_addr = a; pkt_data = d;
    #1;
    while (!pkt_ready) begin
      @(negedge clk);
      #1;
    end
    note_accept(a, d);
    @(posedge clk);
    #1;
    pkt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while ((wb_req_valid || fill_req_valid) && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wb0, n;
    for (int a = 0; a < NA; a++) begin
      mem[a]     = DATA_W'(a * 3);
      ref_sum[a] = DATA_W'(a * 3);
    end
    pkt_valid = 1'b0; pkt_addr = '0; pkt_data = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(pkt_ready == 1'b1, "R1 ready", int'(pkt_ready), 1);
    chk(!wb_req_valid && !fill_req_valid, "R1 no requests",
        int'({wb_req_valid, fill_req_valid}), 0);
    for (int i = 0; i < NL; i++) chk(sv[i] == 1'b0, "R1 line invalid", int'(sv[i]), 0);
    chk_on = 1'b1;

    // R4: miss into an empty line, no writeback
    wb_lat = 1; fill_lat = 2;
    send(8'h05, 16'd7);
    wait_idle();
    chk(wb_count == 0, "R4 no writeback", wb_count, 0);
    chk(sdat[1] == 16'd22 && !sp[1], "R6 fill added", int'(sdat[1]), 22);

    // R2: hit adds in one cycle, marks dirty, no request
    send(8'h05, 16'd3);
    @(negedge clk);
    chk(sdat[1] == 16'd25, "R2 hit sum", int'(sdat[1]), 25);
    chk(sd[1] == 1'b1, "R2 dirty", int'(sd[1]), 1);
    chk(!fill_req_valid && !wb_req_valid, "R2 no request",
        int'({wb_req_valid, fill_req_valid}), 0);

    // R3/R5/R6/R7: dirty victim, slow memory
    wb_lat = 3; fill_lat = 6;
    send(8'h45, 16'd4);
    n = 0;
    while (!fill_req_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(wb_count == 1, "R7 writeback before fill", wb_count, 1);
    chk(last_wb_a == 8'h05, "R3 victim addr", int'(last_wb_a), 5);
    chk(last_wb_d == 16'd25, "R3 victim data", int'(last_wb_d), 25);
    chk(sv[1] && sp[1] && stg[1] == 6'h11, "R5 line pending new tag",
        int'({sp[1], stg[1]}), int'({1'b1, 6'h11}));
    chk(sdat[1] == 16'd4, "R5 operand stored first", int'(sdat[1]), 4);
    chk(fill_req_addr == 8'h45, "R6 fill addr", int'(fill_req_addr), 'h45);
    wait_idle();
    chk(sdat[1] == 16'd211 && !sp[1], "R6 fill-add result", int'(sdat[1]), 211);
    chk(mem[8'h05] == 16'd25, "R3 memory updated", int'(mem[8'h05]), 25);

    // R8/R9: traffic during a pending fill
    wb_lat = 0; fill_lat = 12;
    send(8'h07, 16'd1);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_addr = 8'h07; pkt_data = 16'd9;
    #1 chk(!pkt_ready, "R8 same line held", int'(pkt_ready), 0);
    pkt_addr = 8'h47;
    #1 chk(!pkt_ready, "R8 same index held", int'(pkt_ready), 0);
    pkt_addr = 8'h08;
    #1 chk(!pkt_ready, "R9 other miss held", int'(pkt_ready), 0);
    pkt_addr = 8'h45; pkt_data = 16'd5;
    #1 chk(pkt_ready && fill_req_valid, "R8 other hit accepted",
           int'({pkt_ready, fill_req_valid}), 3);
    note_accept(8'h45, 16'd5);
    @(posedge clk);
    #1 pkt_valid = 1'b0;
    @(negedge clk);
    chk(sdat[1] == 16'd216, "R8 hit during fill", int'(sdat[1]), 216);
    wait_idle();

    // R10: wrap on fill-add and on hit
    fill_lat = 1;
    send(8'h06, 16'hFFF0);
    wait_idle();
    chk(sdat[2] == 16'h0002, "R10 fill wrap", int'(sdat[2]), 2);
    send(8'h06, 16'hFFFF);
    @(negedge clk);
    chk(sdat[2] == 16'h0001, "R10 hit wrap", int'(sdat[2]), 1);

    // random traffic, narrow range, varied latencies (R11 each clock)
    wb0 = wb_count;
    for (int k = 0; k < 600; k++) begin
      wb_lat   = $urandom_range(0, 3);
      fill_lat = $urandom_range(0, 3);
      send(ADDR_W'($urandom_range(0, 23)), DATA_W'($urandom));
    end
    wait_idle();
    chk(wb_count > wb0, "R3 random evictions seen", wb_count - wb0, 1);

    // R11: final sweep of every word
    @(negedge clk);
    done = 1'b1;
    for (int a = 0; a < NA; a++) begin
      logic [ADDR_W-1:0] aa;
      logic [DATA_W-1:0] v;
      int i;
      aa = ADDR_W'(a);
      i  = int'(aa[IDX_W-1:0]);
      if (is_res(aa)) v = sp[i] ? DATA_W'(sdat[i] + mem[aa]) : sdat[i];
      else v = mem[aa];
      chk(v == ref_sum[aa], "R11 final word", int'(v), int'(ref_sum[aa]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule